// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter behind a small register interface that can serve either as a watchdog or as a periodic interval timer. A prescaler divides the system clock by one of eight ratios before the counter sees a tick. In interval mode an overflow sets a flag, raises an interrupt request and lets the counter wrap and keep counting. In watchdog mode an overflow latches a sticky overflow flag. It drives an active-low overflow output for a fixed number of cycles and returns the counter and the control register to their reset values. It raises a one-cycle internal reset request only when resets are enabled.

While the overflow output is low, every register write is discarded and reads of the reset-control register do not count toward clearing the flag. The flag clears only through a read that sees it set and is made after the output has returned high, followed by a write of 0. The block also arbitrates CPU standby requests: a running watchdog turns a deep-standby request into light sleep.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset all three registers read 0x00, ovf_n is 1, and rst_req, irq, go_deep and go_sleep are 0.
- R2: A write changes a register only if bits 15:8 of bus_wdata hold its key: 0xA5 for the control register (address 0), 0x5A for the counter (address 1), 0xC3 for the reset-control register (address 2). The written value is bits 7:0.
- R3: Control bits 2:0 select the prescale divide: codes 0 to 7 give 2, 64, 128, 512, 2048, 8192, 32768 and 131072 system clocks per counter step, counted from the write that sets the enable bit.
- R4: Control layout: bit 5 enables counting and bit 6 selects watchdog (1) or interval (0). In interval mode an overflow from 0xFF sets control bit 7 and drives irq high, the counter wraps and keeps counting, and ovf_n stays high.
- R5: In watchdog mode an overflow sets reset-control bit 7. It drives ovf_n low for exactly 128 cycles and returns the counter and the control register to 0x00.
- R6: rst_req pulses high for exactly one cycle on a watchdog overflow if reset-control bit 6 is 1, and stays low if that bit is 0.
- R7: A write that tries to change the mode bit while the enable bit is 1 leaves the mode unchanged; with the enable bit 0 the mode bit takes the written value.
- R8: While ovf_n is low, keyed writes to all three registers have no effect.
- R9: Reset-control bit 7 clears only on a keyed write with bit 7 = 0 that follows a read of address 2 which returned bit 7 set while ovf_n was high. A read made while ovf_n is low does not count toward this.
- R10: A one-cycle stby_req gives go_deep one cycle later if stby_bit is 1 and the timer is not enabled in watchdog mode. Otherwise it gives go_sleep. The two outputs are never high together.
- R11: A keyed control write with bit 7 = 0 clears the interval flag and irq; writing 1 to bit 7 leaves it as it was.
- R12: Read data appears on bus_rdata one cycle after bus_rd is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 counter, 2 reset control |
| bus_wdata | input | 16 | Key in bits 15:8, value in bits 7:0 |
| bus_rdata | output | 8 | Registered read data |
| ovf_n | output | 1 | Active-low watchdog overflow pulse |
| rst_req | output | 1 | One-cycle internal reset request |
| irq | output | 1 | Interval overflow interrupt request (level) |
| stby_req | input | 1 | CPU standby request strobe |
| stby_bit | input | 1 | CPU asks for deep standby when 1 |
| go_deep | output | 1 | Deep standby granted |
| go_sleep | output | 1 | Light sleep entered instead |

## Verification
The hardest state to reach is the overflow flag being cleared in the right order. This needs a locked read and locked writes made during the 128-cycle low pulse, then a write of 0 that is not preceded by a valid read, and only then a proper read and write. The bench preloads the counter close to 0xFF at the fastest divide, so the watchdog overflows within a few dozen cycles. While ovf_n is low it issues the locked accesses. After the pulse ends it checks that the flag survives the unarmed write and clears only after a fresh read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_RCTL = 2'd2;

  localparam logic [7:0] KEY_CTRL = 8'hA5;
  localparam logic [7:0] KEY_CNT  = 8'h5A;
  localparam logic [7:0] KEY_RCTL = 8'hC3;

  // log2 of the prescale divide for each clock-select code
  function automatic int unsigned pre_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    pre_shift = 1;
      3'd1:    pre_shift = 6;
      3'd2:    pre_shift = 7;
      3'd3:    pre_shift = 9;
      3'd4:    pre_shift = 11;
      3'd5:    pre_shift = 13;
      3'd6:    pre_shift = 15;
      default: pre_shift = 17;
    endcase
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import wdt_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = (PRE_W'(1) << pre_shift(sel)) - PRE_W'(1);
    tick = run && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/wdt_ovf_pulse.sv
module wdt_ovf_pulse #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ovf_n
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      ovf_n  <= 1'b1;
    end else if (start) begin
      left_q <= CW'(LEN);
      ovf_n  <= 1'b0;
    end else begin
      if (left_q != '0) left_q <= left_q - CW'(1);
      ovf_n <= !(left_q > CW'(1));
    end
  end
endmodule

// File: rtl/wdt_standby_gate.sv
module wdt_standby_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic deep_bit,
  input  logic wd_active,
  output logic go_deep,
  output logic go_sleep
);
  logic allow_deep;

  always_comb allow_deep = deep_bit && !wd_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      go_deep  <= 1'b0;
      go_sleep <= 1'b0;
    end else begin
      go_deep  <= req && allow_deep;
      go_sleep <= req && !allow_deep;
    end
  end
endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer #(
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 17,
  parameter int PULSE_LEN = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [1:0]   bus_addr,
  input  logic [15:0]  bus_wdata,
  output logic [7:0]   bus_rdata,
  output logic         ovf_n,
  output logic         rst_req,
  output logic         irq,
  input  logic         stby_req,
  input  logic         stby_bit,
  output logic         go_deep,
  output logic         go_sleep
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             en_q, wd_mode_q, iflag_q;
  logic [2:0]       cks_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rsten_q, oflag_q, armed_q;

  logic       tick, locked, at_top, wd_ovf, iv_ovf;
  logic [7:0] key, wbyte;
  logic       wr_ctrl, wr_cnt, wr_rctl, rd_rctl;

  always_comb begin
    key     = bus_wdata[15:8];
    wbyte   = bus_wdata[7:0];
    locked  = !ovf_n;
    at_top  = (cnt_q == CNT_TOP);
    wd_ovf  = tick && at_top && wd_mode_q;
    iv_ovf  = tick && at_top && !wd_mode_q;
    wr_ctrl = bus_wr && !locked && (bus_addr == ADDR_CTRL) && (key == KEY_CTRL);
    wr_cnt  = bus_wr && !locked && (bus_addr == ADDR_CNT)  && (key == KEY_CNT);
    wr_rctl = bus_wr && !locked && (bus_addr == ADDR_RCTL) && (key == KEY_RCTL);
    rd_rctl = bus_rd && (bus_addr == ADDR_RCTL);
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en_q),
    .sel  (cks_q),
    .tick (tick)
  );

  wdt_ovf_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst   (rst),
    .start (wd_ovf),
    .ovf_n (ovf_n)
  );

  wdt_standby_gate u_stby (
    .clk       (clk),
    .rst       (rst),
    .req       (stby_req),
    .deep_bit  (stby_bit),
    .wd_active (en_q && wd_mode_q),
    .go_deep   (go_deep),
    .go_sleep  (go_sleep)
  );

  // control register and interval flag
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      wd_mode_q <= 1'b0;
      cks_q     <= 3'd0;
      iflag_q   <= 1'b0;
    end else begin
      if (wd_ovf) begin
        en_q      <= 1'b0;
        wd_mode_q <= 1'b0;
        cks_q     <= 3'd0;
      end else if (wr_ctrl) begin
        en_q  <= wbyte[5];
        cks_q <= wbyte[2:0];
        if (!en_q)     wd_mode_q <= wbyte[6];
        if (!wbyte[7]) iflag_q   <= 1'b0;
      end
      if (iv_ovf) iflag_q <= 1'b1;
    end
  end

  // counter
  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wd_ovf) cnt_q <= '0;
    else if (wr_cnt) cnt_q <= CNT_W'(wbyte);
    else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
  end

  // reset-control register, clear protocol, reset request
  always_ff @(posedge clk) begin
    if (rst) begin
      rsten_q <= 1'b0;
      oflag_q <= 1'b0;
      armed_q <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (wd_ovf) begin
        oflag_q <= 1'b1;
        armed_q <= 1'b0;
        rst_req <= rsten_q;
      end else begin
        if (rd_rctl && !locked && oflag_q) armed_q <= 1'b1;
        if (wr_rctl) begin
          rsten_q <= wbyte[6];
          if (!wbyte[7] && armed_q) oflag_q <= 1'b0;
          armed_q <= 1'b0;
        end
      end
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_CTRL: bus_rdata <= {iflag_q, wd_mode_q, en_q, 2'b00, cks_q};
        ADDR_CNT:  bus_rdata <= 8'(cnt_q);
        ADDR_RCTL: bus_rdata <= {oflag_q, rsten_q, 6'b000000};
        default:   bus_rdata <= 8'h00;
      endcase
    end
  end

  always_comb irq = iflag_q;

endmodule

// File: rtl/wdt_dual_timer_chk.sv
module wdt_dual_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ovf_n,
  input logic             rst_req,
  input logic             go_deep,
  input logic             go_sleep,
  input logic             stby_req,
  input logic             en_q,
  input logic             wd_mode_q,
  input logic             rsten_q,
  input logic             oflag_q,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wd_ovf
);
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wd_mode_q != $past(wd_mode_q)) |-> (!$past(en_q) || $past(wd_ovf)));

  p_rst_gate_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> ($past(rsten_q) && $past(wd_ovf)));

  p_rst_single_r6: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!ovf_n && !$past(ovf_n)) |-> ($stable(rsten_q) && $stable(cnt_q) && $stable(en_q)));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(oflag_q) |-> $past(armed_q));

  p_arm_unlocked_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(ovf_n));

  p_deep_gate_r10: assert property (@(posedge clk) disable iff (rst)
    go_deep |-> !($past(en_q) && $past(wd_mode_q)));

  p_stby_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_deep, go_sleep}));

  p_stby_answer_r10: assert property (@(posedge clk) disable iff (rst)
    stby_req |=> (go_deep || go_sleep));
endmodule

bind wdt_dual_timer wdt_dual_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ovf_n     (ovf_n),
  .rst_req   (rst_req),
  .go_deep   (go_deep),
  .go_sleep  (go_sleep),
  .stby_req  (stby_req),
  .en_q      (en_q),
  .wd_mode_q (wd_mode_q),
  .rsten_q   (rsten_q),
  .oflag_q   (oflag_q),
  .armed_q   (armed_q),
  .cnt_q     (cnt_q),
  .wd_ovf    (wd_ovf)
);

// File: tb/wdt_dual_timer_tb.sv
`timescale 1ns/1ps
module wdt_dual_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0]  bus_rdata;
  logic        ovf_n, rst_req, irq;
  logic        stby_req = 1'b0, stby_bit = 1'b0;
  logic        go_deep, go_sleep;

  int checks = 0, fails = 0;
  int low_cycles = 0, rst_pulses = 0, ovf_seen = 0;

  always #5 clk = ~clk;

  wdt_dual_timer u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_n(ovf_n), .rst_req(rst_req),
    .irq(irq), .stby_req(stby_req), .stby_bit(stby_bit), .go_deep(go_deep),
    .go_sleep(go_sleep)
  );

  always @(negedge clk) begin
    if (!ovf_n) begin low_cycles++; ovf_seen = 1; end
    if (rst_req) rst_pulses++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] k, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {k, d};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_ovf_low();
    for (int i = 0; i < 2000 && ovf_n; i++) @(negedge clk);
  endtask

  task automatic wait_ovf_high();
    for (int i = 0; i < 2000 && !ovf_n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(ovf_n == 1 && rst_req == 0 && irq == 0 && go_deep == 0 && go_sleep == 0,
          "R1 outputs after reset", {ovf_n, rst_req, irq, go_deep, go_sleep}, 5'b10000);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 register after reset", d, 0);
    end
  endtask

  task automatic t_keys();
    logic [7:0] d;
    wr(2'd1, 8'h00, 8'h33); rd(2'd1, d);
    check(d == 8'h00, "R2 counter wrong key", d, 0);
    wr(2'd1, 8'h5A, 8'h33); rd(2'd1, d);
    check(d == 8'h33, "R2 counter right key R12", d, 8'h33);
    wr(2'd0, 8'h5A, 8'h47); rd(2'd0, d);
    check(d == 8'h00, "R2 control wrong key", d, 0);
    wr(2'd2, 8'hA5, 8'h40); rd(2'd2, d);
    check(d == 8'h00, "R2 reset-control wrong key", d, 0);
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    wr(2'd1, 8'h5A, 8'h00);
    wr(2'd0, 8'hA5, 8'h21);
    repeat (640) @(negedge clk);
    rd(2'd1, d);
    check(d >= 9 && d <= 11, "R3 divide-by-64 step count", d, 10);
    wr(2'd0, 8'hA5, 8'h00);
    wr(2'd1, 8'h5A, 8'h00);
    wr(2'd0, 8'hA5, 8'h27);
    repeat (200) @(negedge clk);
    rd(2'd1, d);
    check(d == 8'h00, "R3 divide-by-131072 no step", d, 0);
    wr(2'd0, 8'hA5, 8'h00);
  endtask

  task automatic t_interval();
    logic [7:0] d;
    ovf_seen = 0;
    wr(2'd1, 8'h5A, 8'hF0);
    wr(2'd0, 8'hA5, 8'h20);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    check(irq == 1, "R4 interval irq", irq, 1);
    rd(2'd0, d);
    check(d[7] == 1 && d[5] == 1, "R4 interval flag set and still enabled", d, 8'hA0);
    rd(2'd1, d);
    check(d < 8'h20, "R4 counter wrapped", d, 8'h02);
    check(ovf_seen == 0, "R4 no overflow pulse", ovf_seen, 0);
    wr(2'd0, 8'hA5, 8'hA0);
    check(irq == 1, "R11 write of 1 keeps flag", irq, 1);
    wr(2'd0, 8'hA5, 8'h00);
    check(irq == 0, "R11 write of 0 clears flag", irq, 0);
  endtask

  task automatic t_mode_lock();
    logic [7:0] d;
    wr(2'd0, 8'hA5, 8'h20);
    wr(2'd0, 8'hA5, 8'h60);
    rd(2'd0, d);
    check(d == 8'h20, "R7 mode held while running", d, 8'h20);
    wr(2'd0, 8'hA5, 8'h00);
    wr(2'd0, 8'hA5, 8'h40);
    rd(2'd0, d);
    check(d == 8'h40, "R7 mode changes while stopped", d, 8'h40);
    wr(2'd0, 8'hA5, 8'h00);
  endtask

  task automatic t_watchdog_reset();
    logic [7:0] d;
    wr(2'd2, 8'hC3, 8'h40);
    wr(2'd1, 8'h5A, 8'hF0);
    low_cycles = 0; rst_pulses = 0;
    wr(2'd0, 8'hA5, 8'h60);
    wait_ovf_low();
    check(ovf_n == 0, "R5 overflow output low", ovf_n, 0);
    wr(2'd1, 8'h5A, 8'h40);
    wr(2'd0, 8'hA5, 8'h21);
    wr(2'd2, 8'hC3, 8'h00);
    rd(2'd2, d);
    wait_ovf_high();
    check(low_cycles == 128, "R5 pulse width", low_cycles, 128);
    check(rst_pulses == 1, "R6 one reset request", rst_pulses, 1);
    rd(2'd1, d);
    check(d == 8'h00, "R5 R8 counter cleared, locked write lost", d, 0);
    rd(2'd0, d);
    check(d == 8'h00, "R5 R8 control cleared, locked write lost", d, 0);
    wr(2'd2, 8'hC3, 8'h40);
    rd(2'd2, d);
    check(d == 8'hC0, "R9 R8 flag kept without valid read", d, 8'hC0);
    wr(2'd2, 8'hC3, 8'h40);
    rd(2'd2, d);
    check(d == 8'h40, "R9 flag cleared after read then write 0", d, 8'h40);
  endtask

  task automatic t_watchdog_norst();
    logic [7:0] d;
    wr(2'd2, 8'hC3, 8'h00);
    wr(2'd1, 8'h5A, 8'hF8);
    low_cycles = 0; rst_pulses = 0;
    wr(2'd0, 8'hA5, 8'h60);
    wait_ovf_low();
    wait_ovf_high();
    check(rst_pulses == 0, "R6 no reset request when disabled", rst_pulses, 0);
    check(low_cycles == 128, "R5 pulse without reset enable", low_cycles, 128);
    rd(2'd2, d);
    check(d == 8'h80, "R5 flag set without reset enable", d, 8'h80);
    rd(2'd0, d);
    check(d == 8'h00, "R5 control back to 0", d, 0);
  endtask

  task automatic stby(input logic deep, output logic gd, output logic gs);
    @(negedge clk);
    stby_req = 1'b1; stby_bit = deep;
    @(negedge clk);
    stby_req = 1'b0;
    gd = go_deep; gs = go_sleep;
  endtask

  task automatic t_standby();
    logic gd, gs;
    stby(1'b1, gd, gs);
    check(gd && !gs, "R10 stopped timer deep", {gd, gs}, 2'b10);
    wr(2'd1, 8'h5A, 8'h00);
    wr(2'd0, 8'hA5, 8'h67);
    stby(1'b1, gd, gs);
    check(!gd && gs, "R10 running watchdog demotes to sleep", {gd, gs}, 2'b01);
    wr(2'd0, 8'hA5, 8'h00);
    stby(1'b1, gd, gs);
    check(gd && !gs, "R10 stopped watchdog deep", {gd, gs}, 2'b10);
    wr(2'd0, 8'hA5, 8'h27);
    stby(1'b1, gd, gs);
    check(gd && !gs, "R10 interval running deep", {gd, gs}, 2'b10);
    stby(1'b0, gd, gs);
    check(!gd && gs, "R10 no deep bit gives sleep", {gd, gs}, 2'b01);
    wr(2'd0, 8'hA5, 8'h00);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_keys();
    t_prescale();
    t_interval();
    t_mode_lock();
    t_watchdog_reset();
    t_watchdog_norst();
    t_standby();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1-sequence actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule